// File: doc/BRIEF.md
# Signed-Amount Bidirectional Integer Shifter

This block moves a 32-bit or 64-bit integer left or right by a signed count. The sign of the count picks the direction: a left move for a non-negative (or, in register form, strictly positive) count, and an arithmetic right move by the magnitude otherwise. The count comes from one of two places. It can be a 7-bit two's-complement immediate gathered from two separate fields of the instruction word. It can also be a full 32-bit register operand.

In the narrow form only the low 32 bits of the source take part, and the upper 32 bits of the result are the previous upper contents of the destination. The caller supplies those contents on `dst_prev`. The wide form shifts the whole 64-bit source. Each accepted request yields one registered result on the next clock edge. The caller writes that result back into its register file.

Top module: `signed_shifter`

## Requirements
- R1: Each cycle with `in_valid` high yields `out_valid` high with the result one clock edge later, and `out_valid` is low after a cycle without a request. A synchronous reset forces `out_valid` and `out_val` to zero.
- R2: In immediate mode (`amt_from_reg`=0), the count is a 7-bit two's-complement value. Its low four bits are `instr[3:0]` and its upper three bits are `instr[7:5]`, so `instr[7]` is the sign.
- R3: In immediate mode, a count from 0 to 63 shifts left by that count. A count from -1 to -64 shifts right by its magnitude.
- R4: In register mode (`amt_from_reg`=1), `reg_amt` is read as signed. A value above zero shifts left by that value. Zero or a negative value shifts right by its negation, so a zero count returns the operand unchanged.
- R5: Right shifts are arithmetic: vacated bits take the operand's top bit (bit 63 in wide form, bit 31 in narrow form).
- R6: A magnitude equal to or above the operand width (64 wide, 32 narrow) gives all zeros for a left shift and all copies of the sign bit for a right shift. This includes a register count of -2^31.
- R7: In narrow form (`wide_sel`=0), the operand is `src_val[31:0]` and the result goes to `out_val[31:0]`. `out_val[63:32]` equals `dst_prev[63:32]`, and `src_val[63:32]` has no effect.
- R8: In wide form (`wide_sel`=1), all 64 bits of `src_val` are shifted as one value.
- R9: Instruction bits outside the two count fields (`instr[4]`, `instr[31:8]`) have no effect. In immediate mode `reg_amt` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word holding the immediate count fields |
| src_val | input | 64 | Source register value |
| dst_prev | input | 64 | Current destination contents; upper half kept in narrow form |
| reg_amt | input | 32 | Signed count for register mode |
| wide_sel | input | 1 | 1 = 64-bit shift, 0 = 32-bit shift on the low half |
| amt_from_reg | input | 1 | 1 = count from `reg_amt`, 0 = count from the immediate |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_val | output | 64 | Shifted destination value |

## Verification
The only state is the output register, so any defect in count decoding, direction choice or saturation shows up on `out_val` at the first edge after the bad request. Nothing can hide in later cycles. A wrong sign extension of the immediate or a wrong boundary at zero flips the direction, and the result then differs in almost every bit. A wrong saturation threshold shows only at the exact magnitudes 31, 32, 63 and 64, so those are driven on purpose. A corrupted upper half in narrow form shows as a mismatch against `dst_prev` in the same result word.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int unsigned SHF_DATA_W  = 64;
  localparam int unsigned SHF_HALF_W  = 32;
  localparam int unsigned SHF_INSTR_W = 32;
  localparam int unsigned SHF_AMT_W   = 32;

  typedef enum logic {
    AMT_IMM = 1'b0,
    AMT_REG = 1'b1
  } amt_src_e;
endpackage

// File: rtl/shf_amt_decode.sv
module shf_amt_decode #(
  parameter int unsigned INSTR_W    = 32,
  parameter int unsigned AMT_W      = 32,
  parameter int unsigned IMM_LO_W   = 4,
  parameter int unsigned IMM_HI_LSB = 5,
  parameter int unsigned IMM_HI_W   = 3,
  parameter int unsigned MAG_W      = AMT_W + 1
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [AMT_W-1:0]   reg_amt,
  input  shf_pkg::amt_src_e  src_kind,
  output logic               go_left,
  output logic [MAG_W-1:0]   mag
);
  localparam int unsigned IMM_W = IMM_LO_W + IMM_HI_W;

  logic [IMM_W-1:0] imm_raw;
  logic [AMT_W-1:0] imm_ext;
  logic [AMT_W-1:0] amt_sel;
  logic             amt_neg;
  logic [MAG_W-1:0] amt_wide;

  assign imm_raw  = {instr[IMM_HI_LSB +: IMM_HI_W], instr[0 +: IMM_LO_W]};
  assign imm_ext  = {{(AMT_W-IMM_W){imm_raw[IMM_W-1]}}, imm_raw};
  assign amt_sel  = (src_kind == shf_pkg::AMT_REG) ? reg_amt : imm_ext;
  assign amt_neg  = amt_sel[AMT_W-1];
  assign amt_wide = {amt_neg, amt_sel};

  always_comb begin
    if (src_kind == shf_pkg::AMT_REG) go_left = !amt_neg && (amt_sel != '0);
    else                              go_left = !amt_neg;
    mag = go_left ? amt_wide : (~amt_wide + 1'b1);
  end

  // R3: an immediate count never asks for more than 64 positions
  always_comb begin
    if (src_kind == shf_pkg::AMT_IMM)
      p_imm_mag_range_r3: assert (mag <= MAG_W'(64));
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int unsigned W     = 64,
  parameter int unsigned MAG_W = 33
) (
  input  logic [W-1:0]     operand,
  input  logic             go_left,
  input  logic [MAG_W-1:0] mag,
  output logic [W-1:0]     res
);
  localparam int unsigned SH_W = $clog2(W);

  logic [W-1:0] lft [SH_W+1];
  logic [W-1:0] rgt [SH_W+1];
  logic         sign_b;
  logic         sat;

  assign sign_b = operand[W-1];
  assign sat    = |mag[MAG_W-1:SH_W];
  assign lft[0] = operand;
  assign rgt[0] = operand;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int unsigned STEP = 2 ** s;
    assign lft[s+1] = mag[s] ? {lft[s][W-1-STEP:0], {STEP{1'b0}}} : lft[s];
    assign rgt[s+1] = mag[s] ? {{STEP{sign_b}}, rgt[s][W-1:STEP]} : rgt[s];
  end

  always_comb begin
    if (go_left) res = sat ? '0 : lft[SH_W];
    else         res = sat ? {W{sign_b}} : rgt[SH_W];
  end
endmodule

// File: rtl/signed_shifter.sv
module signed_shifter #(
  parameter int unsigned DATA_W  = shf_pkg::SHF_DATA_W,
  parameter int unsigned HALF_W  = shf_pkg::SHF_HALF_W,
  parameter int unsigned INSTR_W = shf_pkg::SHF_INSTR_W,
  parameter int unsigned AMT_W   = shf_pkg::SHF_AMT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  src_val,
  input  logic [DATA_W-1:0]  dst_prev,
  input  logic [AMT_W-1:0]   reg_amt,
  input  logic               wide_sel,
  input  logic               amt_from_reg,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_val
);
  localparam int unsigned MAG_W = AMT_W + 1;

  shf_pkg::amt_src_e src_kind;
  logic              go_left;
  logic [MAG_W-1:0]  mag;
  logic [HALF_W-1:0] res_half;
  logic [DATA_W-1:0] res_full;
  logic [DATA_W-1:0] nxt_val;
  logic              unused_bits;

  assign src_kind    = shf_pkg::amt_src_e'(amt_from_reg);
  assign unused_bits = ^{dst_prev[HALF_W-1:0], instr};

  shf_amt_decode #(.INSTR_W(INSTR_W), .AMT_W(AMT_W), .MAG_W(MAG_W)) u_dec (
    .instr   (instr),
    .reg_amt (reg_amt),
    .src_kind(src_kind),
    .go_left (go_left),
    .mag     (mag)
  );

  shf_barrel #(.W(HALF_W), .MAG_W(MAG_W)) u_half (
    .operand(src_val[HALF_W-1:0]),
    .go_left(go_left),
    .mag    (mag),
    .res    (res_half)
  );

  shf_barrel #(.W(DATA_W), .MAG_W(MAG_W)) u_full (
    .operand(src_val),
    .go_left(go_left),
    .mag    (mag),
    .res    (res_full)
  );

  assign nxt_val = wide_sel ? res_full : {dst_prev[DATA_W-1:HALF_W], res_half};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_val   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_val <= nxt_val;
    end
  end

  // R1: reset clears the output stage
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_val == '0));

  // R1: one-cycle strobe latency
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7: narrow form keeps the destination's upper half
  p_keep_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_sel) |=> out_val[DATA_W-1:HALF_W] == $past(dst_prev[DATA_W-1:HALF_W]));

  // R4: a zero register count leaves a wide operand unchanged
  p_zero_identity_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide_sel && amt_from_reg && reg_amt == '0) |=> out_val == $past(src_val));

  // R6: oversized register counts saturate in the wide form
  p_left_flush_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide_sel && amt_from_reg && $signed(reg_amt) >= 64) |=> out_val == '0);
  p_right_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide_sel && amt_from_reg && $signed(reg_amt) <= -64)
    |=> out_val == {DATA_W{$past(src_val[DATA_W-1])}});
endmodule

// File: tb/test_signed_shifter.sv
module test_signed_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_val = '0;
  logic [63:0] dst_prev = '0;
  logic [31:0] reg_amt = '0;
  logic        wide_sel = 1'b0;
  logic        amt_from_reg = 1'b0;
  logic        out_valid;
  logic [63:0] out_val;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #5 clk = ~clk;

  signed_shifter i_signed_shifter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_val(src_val), .dst_prev(dst_prev), .reg_amt(reg_amt),
    .wide_sel(wide_sel), .amt_from_reg(amt_from_reg),
    .out_valid(out_valid), .out_val(out_val)
  );

  function automatic logic [31:0] mk_instr(input logic [6:0] f, input logic [31:0] noise);
    logic [31:0] w;
    w = noise;
    w[3:0] = f[3:0];
    w[7:5] = f[6:4];
    return w;
  endfunction

  function automatic logic [63:0] ref_shift(input logic [31:0] ins, input logic [63:0] src,
                                            input logic [63:0] prev, input logic [31:0] ramt,
                                            input bit wide, input bit rsel);
    longint a;
    longint m;
    bit left;
    logic [6:0] f;
    logic [63:0] v;
    if (rsel) begin
      a = longint'($signed(ramt));
      left = (a > 0);
    end else begin
      f = {ins[7:5], ins[3:0]};
      a = f[6] ? longint'(f) - 128 : longint'(f);
      left = (a >= 0);
    end
    m = left ? a : -a;
    v = wide ? src : {{32{src[31]}}, src[31:0]};
    for (int i = 0; i < 70; i++)
      if (i < m) v = left ? (v << 1) : {v[63], v[63:1]};
    return wide ? v : {prev[63:32], v[31:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [31:0] ins, input logic [63:0] src,
                      input logic [63:0] prev, input logic [31:0] ramt,
                      input bit wide, input bit rsel);
    sb_item_t it;
    @(negedge clk);
    instr = ins; src_val = src; dst_prev = prev; reg_amt = ramt;
    wide_sel = wide; amt_from_reg = rsel; in_valid = 1'b1;
    it.exp = ref_shift(ins, src, prev, ramt, wide, rsel);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: pops and compares each result
  initial begin
    sb_item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (!rst && out_valid) begin
        if (sb_q.size() == 0) begin
          check("R1 unexpected out_valid", 64'd1, 64'd0);
        end else begin
          it = sb_q.pop_front();
          check(it.tag, out_val, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r_ins;
    logic [63:0] r_src, r_prev;
    logic [31:0] r_amt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset out_val", out_val, 64'd0);

    // immediate mode, wide
    send("R3 imm left 5",   mk_instr(7'd5,    32'h0), 64'h0000_0000_0000_0013, 64'h0, 32'h0, 1, 0);
    send("R2 imm -4 right", mk_instr(7'h7C,   32'h0), 64'h8000_0000_0000_00F0, 64'h0, 32'h0, 1, 0);
    send("R5 imm -1 arith", mk_instr(7'h7F,   32'h0), 64'hF000_0000_0000_0001, 64'h0, 32'h0, 1, 0);
    send("R6 imm -64 fill", mk_instr(7'h40,   32'h0), 64'h9234_5678_9ABC_DEF0, 64'h0, 32'h0, 1, 0);
    send("R6 imm -64 pos",  mk_instr(7'h40,   32'h0), 64'h7234_5678_9ABC_DEF0, 64'h0, 32'h0, 1, 0);
    send("R3 imm left 63",  mk_instr(7'd63,   32'h0), 64'h0000_0000_0000_0003, 64'h0, 32'h0, 1, 0);
    send("R9 other bits",   mk_instr(7'd2,    32'hABCD_E010), 64'h0000_0000_0000_0011, 64'h0, 32'hFFFF_FFF0, 1, 0);
    send("R8 wide crosses", mk_instr(7'd8,    32'h0), 64'h00FF_0000_FF00_0000, 64'h0, 32'h0, 1, 0);
    // immediate mode, narrow
    send("R7 narrow left 4",  mk_instr(7'd4,  32'h0), 64'hDEAD_BEEF_1234_5678, 64'hCAFE_F00D_0000_0000, 32'h0, 0, 0);
    send("R5 narrow right 8", mk_instr(7'h78, 32'h0), 64'h0000_0000_8765_4321, 64'h1111_2222_3333_4444, 32'h0, 0, 0);
    send("R6 narrow left 40", mk_instr(7'd40, 32'h0), 64'h0000_0000_FFFF_FFFF, 64'h5555_AAAA_0000_0000, 32'h0, 0, 0);
    send("R6 narrow right 40",mk_instr(7'h58, 32'h0), 64'h0000_0000_8000_0001, 64'h0123_4567_89AB_CDEF, 32'h0, 0, 0);
    send("R6 narrow left 31", mk_instr(7'd31, 32'h0), 64'hFFFF_FFFF_0000_0003, 64'h7777_7777_0000_0000, 32'h0, 0, 0);
    send("R6 narrow left 32", mk_instr(7'd32, 32'h0), 64'h0000_0000_0000_0001, 64'h7777_7777_0000_0000, 32'h0, 0, 0);
    go_idle();
    @(negedge clk);
    @(negedge clk);
    check("R1 idle out_valid", {63'd0, out_valid}, 64'd0);

    // register mode
    send("R4 reg zero",    32'hFFFF_FFFF, 64'hA5A5_5A5A_0F0F_F0F0, 64'h0, 32'd0,          1, 1);
    send("R4 reg +1",      32'h0,         64'h8000_0000_0000_0001, 64'h0, 32'd1,          1, 1);
    send("R4 reg -1",      32'h0,         64'h8000_0000_0000_0002, 64'h0, 32'hFFFF_FFFF,  1, 1);
    send("R6 reg +64",     32'h0,         64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'd64,         1, 1);
    send("R6 reg -2^31",   32'h0,         64'h8000_0000_0000_0000, 64'h0, 32'h8000_0000,  1, 1);
    send("R6 reg +100",    32'h0,         64'h0000_0000_0000_0001, 64'h0, 32'd100,        1, 1);
    send("R4 reg -63",     32'h0,         64'hC000_0000_0000_0000, 64'h0, 32'hFFFF_FFC1,  1, 1);
    send("R7 reg narrow",  32'h0,         64'hFFFF_0000_4000_0000, 64'hBEEF_BEEF_0000_0000, 32'hFFFF_FFE2, 0, 1);
    send("R7 reg narrow zero", 32'h0,     64'h1234_5678_9ABC_DEF0, 64'h0BAD_F00D_0000_0000, 32'd0, 0, 1);
    go_idle();

    for (int k = 0; k < 200; k++) begin
      r_ins  = $urandom;
      r_src  = {$urandom, $urandom};
      r_prev = {$urandom, $urandom};
      r_amt  = (k % 3 == 0) ? $urandom : (32'($urandom_range(0, 140)) - 32'd70);
      send("R8 random", r_ins, r_src, r_prev, r_amt, k[0], k[1]);
    end
    go_idle();
    repeat (4) @(negedge clk);
    check("R1 scoreboard drained", 64'(sb_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule